// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block brings an Ethernet PHY from an unknown state to a negotiated link. It does this by issuing register reads and writes, one at a time, to an MDIO management master over a simple request/acknowledge handshake. After a start pulse it:

- soft-resets the PHY and waits for the reset bit to self-clear;
- masks every PHY interrupt source;
- copies the PHY's own technology abilities into the autonegotiation advertisement;
- restarts negotiation and polls status until negotiation completes or the retry budget runs out.

A remote fault reported while negotiation is still open causes a further negotiation restart.

Waits between polls are counted in pulses of a `tick` strobe, so the interval depends only on the strobe rate and `WAIT_TICKS`. When the sequence ends, the block holds four results until the next start: a done flag, a link-configured or failed verdict, and the last status word read during negotiation. The block does not handle the MDIO serial framing, decode the link partner's abilities, or force speed or duplex.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `reqValid`, `done`, `linkConfigured` and `failed` are 0 and `statusWord` is 0x0000. The block issues no request until `start` is seen high.
- R2: The first request after an accepted start is a write to register 0 with data 0x8000, which is bit 15 (soft reset) alone.
- R3: Only one request is outstanding at a time. A transfer completes in a cycle where `reqValid` and `reqAck` are both high, and `rspData` is taken in that cycle. While `reqValid` is high and `reqAck` is low, `reqWrite`, `reqReg` and `reqWdata` hold steady.
- R4: Register 0 is then read until a read returns bit 15 clear, for at most `RST_TRIES` reads. Between one of these reads and the next, the block waits exactly `WAIT_TICKS` tick pulses counted after the acknowledge.
- R5: If all `RST_TRIES` reads return bit 15 set, the sequence ends with `done`=1, `failed`=1 and `linkConfigured`=0, `statusWord` stays 0x0000, and no further requests are issued.
- R6: Once reset has cleared, the block writes 0xFFFF to register 18 (all interrupt sources masked) and then reads register 1 once to obtain the ability bits.
- R7: Next comes a write to register 4. Its data is 0x0001 (selector) plus one advertisement bit for each ability bit set in that register 1 read, mapped as follows:

  | Ability | Status bit | Advertisement bit |
  |---------|------------|-------------------|
  | 100BASE-T4 | 15 | 9 |
  | 100 full duplex | 14 | 8 |
  | 100 half duplex | 13 | 7 |
  | 10 full duplex | 12 | 6 |
  | 10 half duplex | 11 | 5 |

  No other status bit affects the data.
- R8: The block then writes 0x1200 to register 0, setting bit 12 (negotiation enable) and bit 9 (restart), and begins polling register 1.
- R9: Polling reads register 1 at most `POLL_TRIES` times, with exactly `WAIT_TICKS` tick pulses between consecutive poll reads. It stops at the first read with bit 5 (negotiation complete) set. `statusWord` holds the last poll read.
- R10: A poll read with bit 5 clear and bit 4 (remote fault) set is followed at once, before any wait, by a write of 0x3300 to register 0. That value sets bits 13, 12, 9 and 8.
- R11: Negotiation fails if `POLL_TRIES` polls pass without bit 5, or if the completing read also has bit 4 set. On failure the block ends with `failed`=1 and `linkConfigured`=0; otherwise it ends with `linkConfigured`=1 and `failed`=0.
- R12: When the sequence ends, the block sets `done`, and `done`, the verdict and `statusWord` hold until the next accepted start. `start` is ignored while a sequence runs. A start while `done` is high clears the results and re-runs the sequence from R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up when idle or finished |
| tick | input | 1 | Interval strobe, one pulse per wait unit |
| reqValid | output | 1 | Register access request pending |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqReg | output | 5 | PHY register number |
| reqWdata | output | 16 | Write data (0 on reads) |
| reqAck | input | 1 | Access completed this cycle |
| rspData | input | 16 | Read data, valid with `reqAck` |
| done | output | 1 | Sequence finished |
| linkConfigured | output | 1 | Negotiation completed without fault |
| failed | output | 1 | Reset timeout, negotiation timeout or fault |
| statusWord | output | 16 | Last status word read while polling |

## Verification
After an acknowledge, the next request is presented in the following cycle. The exception is a request that follows a wait: it appears in the cycle after the `WAIT_TICKS`-th tick that the block samples after the acknowledge. The final verdict and `done` appear in the cycle after the last acknowledge.

The bench drives and samples on falling edges and logs every completed transfer. For each transfer it records how many ticks it drove between the previous acknowledge and the new request, and checks that count against 0 or `WAIT_TICKS` as the requirements dictate. Results are read only after the sequence has settled, and again several cycles later, to confirm that they hold.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int REG_AW = 5;
  localparam int DATA_W = 16;

  localparam logic [REG_AW-1:0] REG_CTRL    = 5'd0;
  localparam logic [REG_AW-1:0] REG_STAT    = 5'd1;
  localparam logic [REG_AW-1:0] REG_ADV     = 5'd4;
  localparam logic [REG_AW-1:0] REG_IRQMASK = 5'd18;

  // control register bits
  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_SPEED_BIT   = 13;
  localparam int CTL_ANEG_EN_BIT = 12;
  localparam int CTL_RESTART_BIT = 9;
  localparam int CTL_DUPLEX_BIT  = 8;

  // status register bits
  localparam int ST_CAP_LO       = 11;
  localparam int CAP_N           = 5;
  localparam int ST_ANEG_DONE    = 5;
  localparam int ST_REM_FAULT    = 4;

  // advertisement layout
  localparam int ADV_CAP_LO      = 5;

  localparam logic [DATA_W-1:0] ONE_W          = 16'h0001;
  localparam logic [DATA_W-1:0] CTL_RESET_WORD = ONE_W << CTL_RESET_BIT;
  localparam logic [DATA_W-1:0] CTL_ANEG_WORD  = (ONE_W << CTL_ANEG_EN_BIT) | (ONE_W << CTL_RESTART_BIT);
  localparam logic [DATA_W-1:0] CTL_FAULT_WORD = CTL_ANEG_WORD | (ONE_W << CTL_SPEED_BIT) | (ONE_W << CTL_DUPLEX_BIT);
  localparam logic [DATA_W-1:0] IRQ_MASK_ALL   = 16'hFFFF;
  localparam logic [DATA_W-1:0] ADV_SELECTOR   = ONE_W;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_RD, S_RST_WAIT, S_MASK_WR, S_CAP_RD,
    S_ADV_WR, S_ANEG_WR, S_POLL_RD, S_FLT_WR, S_POLL_WAIT, S_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RESET_WR, OP_CTRL_RD, OP_MASK_WR,
    OP_STAT_RD, OP_ADV_WR, OP_ANEG_WR, OP_FAULT_WR
  } reqOp_t;

  // strobes from control to datapath
  typedef struct packed {
    reqOp_t op;
    logic   clrRun;
    logic   clrTry;
    logic   startWait;
    logic   waitEn;
    logic   capLoad;
    logic   statLoad;
    logic   finish;
    logic   finFail;
  } dpCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic resetClear;
    logic negDone;
    logic remFault;
    logic rstLast;
    logic pollLast;
    logic waitDone;
  } dpFlags_t;

endpackage

// File: rtl/phy_bringup_dp.sv
module phy_bringup_dp
  import phy_bringup_pkg::*;
#(
  parameter int RST_TRIES  = 6,
  parameter int POLL_TRIES = 20,
  parameter int WAIT_TICKS = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  dpCtrl_t           ctl,
  input  logic [DATA_W-1:0] rspData,
  output dpFlags_t          flags,
  output logic              reqWrite,
  output logic [REG_AW-1:0] reqReg,
  output logic [DATA_W-1:0] reqWdata,
  output logic              done,
  output logic              linkConfigured,
  output logic              failed,
  output logic [DATA_W-1:0] statusWord
);

  localparam int MAX_TRIES = (RST_TRIES > POLL_TRIES) ? RST_TRIES : POLL_TRIES;
  localparam int TRY_W     = $clog2(MAX_TRIES + 1);
  localparam int WAIT_W    = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;

  logic [TRY_W-1:0]  tryCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [CAP_N-1:0]  capBits;
  logic [DATA_W-1:0] advWord;

  // attempt and interval counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tryCnt  <= '0;
      waitCnt <= '0;
    end else begin
      if (ctl.clrTry)         tryCnt <= '0;
      else if (ctl.startWait) tryCnt <= tryCnt + 1'b1;
      if (ctl.startWait)             waitCnt <= '0;
      else if (ctl.waitEn && tick)   waitCnt <= waitCnt + 1'b1;
    end
  end

  // captured words and results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capBits        <= '0;
      statusWord     <= '0;
      done           <= 1'b0;
      failed         <= 1'b0;
      linkConfigured <= 1'b0;
    end else if (ctl.clrRun) begin
      capBits        <= '0;
      statusWord     <= '0;
      done           <= 1'b0;
      failed         <= 1'b0;
      linkConfigured <= 1'b0;
    end else begin
      if (ctl.capLoad)  capBits    <= rspData[ST_CAP_LO +: CAP_N];
      if (ctl.statLoad) statusWord <= rspData;
      if (ctl.finish) begin
        done           <= 1'b1;
        failed         <= ctl.finFail;
        linkConfigured <= !ctl.finFail;
      end
    end
  end

  // ability bits move down into the advertisement field
  for (genvar i = 0; i < DATA_W; i++) begin : g_adv
    if (i >= ADV_CAP_LO && i < ADV_CAP_LO + CAP_N) begin : g_cap
      assign advWord[i] = capBits[i - ADV_CAP_LO];
    end else begin : g_fix
      assign advWord[i] = ADV_SELECTOR[i];
    end
  end

  // request content
  always_comb begin
    reqWrite = 1'b0;
    reqReg   = REG_CTRL;
    reqWdata = '0;
    unique case (ctl.op)
      OP_RESET_WR: begin reqWrite = 1'b1; reqReg = REG_CTRL;    reqWdata = CTL_RESET_WORD; end
      OP_CTRL_RD:  begin reqWrite = 1'b0; reqReg = REG_CTRL;    end
      OP_MASK_WR:  begin reqWrite = 1'b1; reqReg = REG_IRQMASK; reqWdata = IRQ_MASK_ALL;   end
      OP_STAT_RD:  begin reqWrite = 1'b0; reqReg = REG_STAT;    end
      OP_ADV_WR:   begin reqWrite = 1'b1; reqReg = REG_ADV;     reqWdata = advWord;        end
      OP_ANEG_WR:  begin reqWrite = 1'b1; reqReg = REG_CTRL;    reqWdata = CTL_ANEG_WORD;  end
      OP_FAULT_WR: begin reqWrite = 1'b1; reqReg = REG_CTRL;    reqWdata = CTL_FAULT_WORD; end
      default:     begin reqWrite = 1'b0; reqReg = REG_CTRL;    end
    endcase
  end

  always_comb begin
    flags.resetClear = !rspData[CTL_RESET_BIT];
    flags.negDone    = rspData[ST_ANEG_DONE];
    flags.remFault   = rspData[ST_REM_FAULT];
    flags.rstLast    = (tryCnt == TRY_W'(RST_TRIES - 1));
    flags.pollLast   = (tryCnt == TRY_W'(POLL_TRIES - 1));
    flags.waitDone   = tick && (waitCnt == WAIT_W'(WAIT_TICKS - 1));
  end

endmodule

// File: rtl/phy_bringup_ctrl.sv
module phy_bringup_ctrl
  import phy_bringup_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     reqAck,
  input  dpFlags_t flags,
  output logic     reqValid,
  output dpCtrl_t  ctl
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ctl.op    = OP_NONE;
    reqValid  = 1'b0;
    unique case (state)
      S_IDLE, S_DONE: begin
        if (start) begin
          ctl.clrRun = 1'b1;
          ctl.clrTry = 1'b1;
          stateNext  = S_RST_WR;
        end
      end
      S_RST_WR: begin
        reqValid = 1'b1;
        ctl.op   = OP_RESET_WR;
        if (reqAck) stateNext = S_RST_RD;
      end
      S_RST_RD: begin
        reqValid = 1'b1;
        ctl.op   = OP_CTRL_RD;
        if (reqAck) begin
          if (flags.resetClear) begin
            stateNext = S_MASK_WR;
          end else if (flags.rstLast) begin
            ctl.finish  = 1'b1;
            ctl.finFail = 1'b1;
            stateNext   = S_DONE;
          end else begin
            ctl.startWait = 1'b1;
            stateNext     = S_RST_WAIT;
          end
        end
      end
      S_RST_WAIT: begin
        ctl.waitEn = 1'b1;
        if (flags.waitDone) stateNext = S_RST_RD;
      end
      S_MASK_WR: begin
        reqValid = 1'b1;
        ctl.op   = OP_MASK_WR;
        if (reqAck) stateNext = S_CAP_RD;
      end
      S_CAP_RD: begin
        reqValid = 1'b1;
        ctl.op   = OP_STAT_RD;
        if (reqAck) begin
          ctl.capLoad = 1'b1;
          stateNext   = S_ADV_WR;
        end
      end
      S_ADV_WR: begin
        reqValid = 1'b1;
        ctl.op   = OP_ADV_WR;
        if (reqAck) begin
          ctl.clrTry = 1'b1;
          stateNext  = S_ANEG_WR;
        end
      end
      S_ANEG_WR: begin
        reqValid = 1'b1;
        ctl.op   = OP_ANEG_WR;
        if (reqAck) stateNext = S_POLL_RD;
      end
      S_POLL_RD: begin
        reqValid = 1'b1;
        ctl.op   = OP_STAT_RD;
        if (reqAck) begin
          ctl.statLoad = 1'b1;
          if (flags.negDone) begin
            ctl.finish  = 1'b1;
            ctl.finFail = flags.remFault;
            stateNext   = S_DONE;
          end else if (flags.remFault) begin
            stateNext = S_FLT_WR;
          end else if (flags.pollLast) begin
            ctl.finish  = 1'b1;
            ctl.finFail = 1'b1;
            stateNext   = S_DONE;
          end else begin
            ctl.startWait = 1'b1;
            stateNext     = S_POLL_WAIT;
          end
        end
      end
      S_FLT_WR: begin
        reqValid = 1'b1;
        ctl.op   = OP_FAULT_WR;
        if (reqAck) begin
          if (flags.pollLast) begin
            ctl.finish  = 1'b1;
            ctl.finFail = 1'b1;
            stateNext   = S_DONE;
          end else begin
            ctl.startWait = 1'b1;
            stateNext     = S_POLL_WAIT;
          end
        end
      end
      S_POLL_WAIT: begin
        ctl.waitEn = 1'b1;
        if (flags.waitDone) stateNext = S_POLL_RD;
      end
      default: stateNext = S_IDLE;
    endcase
  end

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int RST_TRIES  = 6,
  parameter int POLL_TRIES = 20,
  parameter int WAIT_TICKS = 500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        tick,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [4:0]  reqReg,
  output logic [15:0] reqWdata,
  input  logic        reqAck,
  input  logic [15:0] rspData,
  output logic        done,
  output logic        linkConfigured,
  output logic        failed,
  output logic [15:0] statusWord
);

  dpCtrl_t  ctl;
  dpFlags_t flags;

  phy_bringup_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqAck   (reqAck),
    .flags    (flags),
    .reqValid (reqValid),
    .ctl      (ctl)
  );

  phy_bringup_dp #(
    .RST_TRIES  (RST_TRIES),
    .POLL_TRIES (POLL_TRIES),
    .WAIT_TICKS (WAIT_TICKS)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .tick           (tick),
    .ctl            (ctl),
    .rspData        (rspData),
    .flags          (flags),
    .reqWrite       (reqWrite),
    .reqReg         (reqReg),
    .reqWdata       (reqWdata),
    .done           (done),
    .linkConfigured (linkConfigured),
    .failed         (failed),
    .statusWord     (statusWord)
  );

endmodule

// File: rtl/phy_bringup_seq_chk.sv
module phy_bringup_seq_chk
  import phy_bringup_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        tick,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [4:0]  reqReg,
  input logic [15:0] reqWdata,
  input logic        reqAck,
  input logic [15:0] rspData,
  input logic        done,
  input logic        linkConfigured,
  input logic        failed,
  input logic [15:0] statusWord
);

  logic polling;
  logic xfer;
  assign xfer = reqValid && reqAck;

  always_ff @(posedge clk) begin
    if (!rstN) polling <= 1'b0;
    else if (xfer && reqWrite && reqReg == REG_CTRL && reqWdata == CTL_RESET_WORD) polling <= 1'b0;
    else if (xfer && reqWrite && reqReg == REG_CTRL && reqWdata == CTL_ANEG_WORD)  polling <= 1'b1;
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqWrite) && $stable(reqReg) && $stable(reqWdata));

  assert_restart_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    start && done |=> reqValid && reqWrite && reqReg == REG_CTRL && reqWdata == CTL_RESET_WORD && !done);

  assert_quiet_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqValid);

  assert_mask_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && reqReg == REG_IRQMASK |-> reqWdata == IRQ_MASK_ALL);

  assert_adv_shape_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && reqReg == REG_ADV |-> reqWdata[0] && reqWdata[15:10] == '0 && reqWdata[4:1] == '0);

  assert_fault_rewrite_R10: assert property (@(posedge clk) disable iff (!rstN)
    polling && xfer && !reqWrite && reqReg == REG_STAT && !rspData[ST_ANEG_DONE] && rspData[ST_REM_FAULT]
    |=> reqValid && reqWrite && reqReg == REG_CTRL && reqWdata == CTL_FAULT_WORD);

  assert_verdict_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> failed != linkConfigured);

  assert_no_verdict_R12: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> !failed && !linkConfigured);

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(failed) && $stable(linkConfigured) && $stable(statusWord));

endmodule

bind phy_bringup_seq phy_bringup_seq_chk uChk (.*);

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;

  localparam int RT = 6;
  localparam int PT = 20;
  localparam int WT = 3;
  localparam int LAT = 2;
  localparam int TICK_PER = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic tick = 1'b0;
  logic reqAck = 1'b0;
  logic [15:0] rspData = '0;
  logic reqValid, reqWrite, done, linkConfigured, failed;
  logic [4:0] reqReg;
  logic [15:0] reqWdata, statusWord;

  always #5 clk = ~clk;

  phy_bringup_seq #(.RST_TRIES(RT), .POLL_TRIES(PT), .WAIT_TICKS(WT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .tick(tick),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReg(reqReg), .reqWdata(reqWdata),
    .reqAck(reqAck), .rspData(rspData),
    .done(done), .linkConfigured(linkConfigured), .failed(failed), .statusWord(statusWord)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // PHY model configuration
  logic [4:0]  caps = '0;
  int          rstAt = 1;
  int          anegAt = 1;
  logic [31:0] faultMask = '0;
  int          ctrlReads = 0;
  int          statReads = 0;

  // transfer log
  bit          logW[0:63];
  int          logReg[0:63];
  logic [15:0] logData[0:63];
  int          logTicks[0:63];
  int          logN = 0;

  function automatic logic [15:0] pollWord(input int p);
    logic [15:0] w;
    w = {caps, 11'b0} | 16'h0008;
    if (p >= anegAt) w = w | 16'h0020;
    if (p >= 1 && p <= 32 && faultMask[p-1]) w = w | 16'h0010;
    return w;
  endfunction

  // responder and tick source, all on falling edges
  initial begin
    int lat = 0;
    int tickCnt = 0;
    int pendTicks = 0;
    int phase = 0;
    bit newReq = 1;
    logic [4:0] seenReg;
    logic seenW;
    logic [15:0] seenD;
    seenReg = '0; seenW = 1'b0; seenD = '0;
    forever begin
      @(negedge clk);
      if (reqAck) begin
        reqAck = 1'b0;
        tickCnt = 0;
        newReq = 1;
        lat = 0;
      end
      if (rstN && reqValid) begin
        if (newReq) begin
          pendTicks = tickCnt;
          newReq = 0;
          seenReg = reqReg; seenW = reqWrite; seenD = reqWdata;
        end
        lat++;
        if (lat == LAT) begin
          chk(seenReg == reqReg && seenW == reqWrite && seenD == reqWdata, "R3", "request held until ack",
              {reqWrite, reqReg, reqWdata}, {seenW, seenReg, seenD});
          if (reqReg == 5'd0 && !reqWrite) begin
            ctrlReads++;
            rspData = (ctrlReads < rstAt) ? 16'h9000 : 16'h1000;
          end else if (reqReg == 5'd1 && !reqWrite) begin
            statReads++;
            if (statReads == 1) rspData = {caps, 11'b0} | 16'h0030;
            else rspData = pollWord(statReads - 1);
          end else begin
            rspData = 16'hDEAD;
          end
          if (logN < 64) begin
            logW[logN] = reqWrite;
            logReg[logN] = int'(reqReg);
            logData[logN] = reqWdata;
            logTicks[logN] = pendTicks;
            logN++;
          end
          reqAck = 1'b1;
        end
      end
      phase = (phase + 1) % TICK_PER;
      tick = (phase == 0);
      if (tick) tickCnt++;
    end
  end

  // expected transfer list
  bit          expW[0:63];
  int          expReg[0:63];
  logic [15:0] expData[0:63];
  int          expTicks[0:63];
  string       expTag[0:63];
  int          expN;
  bit          eFail;
  logic [15:0] eStat;

  task automatic addExp(input bit w, input int r, input logic [15:0] d, input int t, input string tag);
    expW[expN] = w; expReg[expN] = r; expData[expN] = d; expTicks[expN] = t; expTag[expN] = tag;
    expN++;
  endtask

  task automatic buildExp();
    bit cleared = 0;
    logic [15:0] w;
    expN = 0; eStat = '0; eFail = 0;
    addExp(1, 0, 16'h8000, 0, "R2");
    for (int n = 1; n <= RT; n++) begin
      addExp(0, 0, 16'h0, (n > 1) ? WT : 0, "R4");
      if (n >= rstAt) begin cleared = 1; break; end
    end
    if (!cleared) begin eFail = 1; return; end
    addExp(1, 18, 16'hFFFF, 0, "R6");
    addExp(0, 1, 16'h0, 0, "R6");
    addExp(1, 4, 16'h0001 | (16'(caps) << 5), 0, "R7");
    addExp(1, 0, 16'h1200, 0, "R8");
    for (int p = 1; p <= PT; p++) begin
      addExp(0, 1, 16'h0, (p > 1) ? WT : 0, "R9");
      w = pollWord(p);
      eStat = w;
      if (w[5]) begin eFail = w[4]; break; end
      if (w[4]) addExp(1, 0, 16'h3300, 0, "R10");
      if (p == PT) eFail = 1;
    end
  endtask

  task automatic runCase(input string name, input logic [4:0] c, input int ra, input int aa,
                         input logic [31:0] fm, input bit midStart);
    int cyc = 0;
    int n;
    caps = c; rstAt = ra; anegAt = aa; faultMask = fm;
    ctrlReads = 0; statReads = 0; logN = 0;
    buildExp();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !failed && !linkConfigured, "R12", {name, " results cleared by start"},
        {done, failed, linkConfigured}, 0);
    if (midStart) begin
      repeat (15) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(done, "R12", {name, " done reached"}, done, 1);
    n = logN;
    repeat (8) @(negedge clk);
    chk(logN == n, "R12", {name, " no requests after done"}, logN, n);
    chk(done, "R12", {name, " done held"}, done, 1);
    chk(logN == expN, midStart ? "R12" : "R9", {name, " transfer count"}, logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logW[i] == expW[i] && logReg[i] == expReg[i], expTag[i], {name, " access kind/reg"},
          {logW[i], 8'(logReg[i])}, {expW[i], 8'(expReg[i])});
      if (expW[i]) chk(logData[i] == expData[i], expTag[i], {name, " write data"}, logData[i], expData[i]);
      if (i > 0) chk(logTicks[i] == expTicks[i], expTag[i], {name, " ticks before request"}, logTicks[i], expTicks[i]);
    end
    chk(failed == eFail, eFail && ra > RT ? "R5" : "R11", {name, " failed"}, failed, eFail);
    chk(linkConfigured == !eFail, "R11", {name, " linkConfigured"}, linkConfigured, !eFail);
    chk(statusWord == eStat, ra > RT ? "R5" : "R9", {name, " statusWord"}, statusWord, eStat);
  endtask

  initial begin
    #1_800_000;
    nChecks++; nFails++;
    $display("FAIL watchdog (R12): actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqValid && !done && !failed && !linkConfigured && statusWord == 16'h0, "R1", "reset state",
        {reqValid, done, failed, linkConfigured}, 0);
    repeat (10) @(negedge clk);
    chk(logN == 0 && !reqValid, "R1", "idle without start", logN, 0);

    // ability sweep (R7)
    for (int c = 0; c < 32; c++) runCase("caps", 5'(c), 1, 1, 32'h0, 0);
    // reset poll length, including timeout (R4, R5)
    for (int r = 1; r <= RT + 1; r++) runCase("rstpoll", 5'h1F, r, 2, 32'h0, 0);
    // negotiation poll length, including exhaustion (R9, R11)
    for (int a = 1; a <= PT + 1; a++) runCase("negpoll", 5'h0A, 1, a, 32'h0, 0);
    // remote fault handling (R10, R11)
    runCase("fault_early", 5'h0A, 2, 3, 32'h0000_0003, 0);
    runCase("fault_at_done", 5'h11, 1, 3, 32'h0000_0004, 0);
    runCase("fault_last", 5'h04, 1, PT + 1, 32'h0008_0000, 0);
    runCase("fault_all", 5'h1F, 1, PT + 1, 32'hFFFF_FFFF, 0);
    // start while running is ignored (R12)
    runCase("midstart", 5'h15, 3, 4, 32'h0000_0002, 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule